// File: doc/BRIEF.md
# Xon/Xoff Software Flow Controller

This block carries in-band flow control for one serial channel. On the receive side it watches every decoded incoming character against a programmable "resume" code and a programmable "stop" code, each one or two bytes long. It keeps a local pause status, which stops the local transmitter from taking new data out of its FIFO.

On the transmit side it tracks the fill level of the local receive FIFO against an upper and a lower threshold. From that it asks the serializer to insert a stop or resume code into the outgoing stream. The controller has a status bit for what the far end was last told, and the thresholds act with hysteresis around it.

The serializer sends an inserted code in preference to FIFO data, but only between characters. It acknowledges each byte with `ins_ack` when that byte starts. The serializers and FIFOs are outside this block.

Top module: `swfc_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `tx_pause`, `ins_req` and `xoff_irq` are all 0.
- R2: Transmit mode `tx_mode` uses this encoding: 00 = transmit-side control off, 01 = send the first byte of a code, 10 = send the second byte of a code, 11 = send both bytes, first then second. While the mode is 00, `ins_req` is 0 from the next cycle, and the far end is taken to be running. After re-enabling, a full FIFO therefore sends a stop code again.
- R3: With the far end taken as running, a stop-code insertion is requested in the cycle after `rx_level` becomes strictly greater than `thr_hi`. A level equal to `thr_hi` requests nothing, and a level that stays high does not repeat the request.
- R4: No resume code is sent when control is enabled or while the far end is taken as running. After a stop code has been issued, a resume code is requested in the cycle after `rx_level` is at or below `thr_lo`.
- R5: While `ins_req` is 1 and `ins_ack` is 0, `ins_req` and `ins_code` hold their values. In mode 11 the first byte is presented until it is acknowledged, and then the second byte is presented until it is acknowledged.
- R6: Receive mode `rx_mode` uses this encoding: 00 = off (status forced to running, no interrupt), 01 = single byte matching code 1, 10 = single byte matching code 2, 11 = code 1 followed by code 2.
- R7: A recognised stop code sets `tx_pause` in the cycle after its strobe. A recognised resume code clears the pause status in the cycle after its strobe.
- R8: In two-byte mode a repeated first byte keeps the partial match, and idle cycles between the two bytes do not break it. Any other character clears the partial match.
- R9: With `xon_any` set, any received character clears the pause status, except a recognised stop code, which takes precedence. With `xon_any` clear, other characters leave the status unchanged.
- R10: `xoff_irq` is a pulse one cycle long, in the cycle after each recognised stop code. It pulses even when the status is already paused.
- R11: `tx_pause` is 1 while the status is paused or an insertion is pending. This gives an inserted code priority over the next FIFO character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_mode | input | 2 | Transmit-side code selection (R2 encoding) |
| rx_mode | input | 2 | Receive-side recognition mode (R6 encoding) |
| xon_any | input | 1 | Any received character resumes transmission |
| xon_code1 | input | 8 | Resume code, first byte |
| xon_code2 | input | 8 | Resume code, second byte |
| xoff_code1 | input | 8 | Stop code, first byte |
| xoff_code2 | input | 8 | Stop code, second byte |
| thr_hi | input | CNT_W | Upper receive-level threshold |
| thr_lo | input | CNT_W | Lower receive-level threshold |
| rx_stb | input | 1 | One-cycle strobe for a received character |
| rx_char | input | 8 | Received character |
| rx_level | input | CNT_W | Current receive FIFO fill level |
| ins_ack | input | 1 | Serializer has started the offered code byte |
| tx_pause | output | 1 | Do not start a FIFO character |
| ins_req | output | 1 | A code byte is offered for insertion |
| ins_code | output | 8 | The offered code byte |
| xoff_irq | output | 1 | Stop code recognised (pulse) |

## Verification
The assertions check these properties on every cycle:
- an offered byte stays put until it is acknowledged;
- disabling either side clears its outputs;
- an interrupt pulse always follows a character strobe and comes with the paused status;
- the pause status never clears without a received character.

Only the bench's scenarios can show:
- which byte is sent in each mode;
- the threshold edges (equal versus greater, no start-up resume code);
- the two-byte matcher's handling of repeated and foreign characters;
- the resume-on-any rule against a competing stop code.

The bench compares all four outputs every cycle with a behavioural model.

// File: rtl/swfc_pkg.sv
// Shared encodings for the software flow controller.
package swfc_pkg;
    // Mode field encoding used by both the transmit and receive sides.
    typedef enum logic [1:0] {
        FC_OFF    = 2'b00,
        FC_FIRST  = 2'b01,
        FC_SECOND = 2'b10,
        FC_PAIR   = 2'b11
    } fc_mode_e;

    // Insertion sequencer states.
    typedef enum logic [1:0] {
        TG_IDLE  = 2'b00,
        TG_BYTE1 = 2'b01,
        TG_BYTE2 = 2'b10
    } tg_state_e;
endpackage

// File: rtl/swfc_rxmatch.sv
// Recognises one programmed code (one or two bytes) in the received stream.
// Assumes: stb is high for exactly one cycle per received character.
// hit is combinational and valid in the strobe cycle.
module swfc_rxmatch
    import swfc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic [DW-1:0] code_a,
    input  logic [DW-1:0] code_b,
    input  logic          stb,
    input  logic [DW-1:0] data,
    output logic          hit
);
    fc_mode_e md;
    logic     armed;

    assign md = fc_mode_e'(mode);

    // Decide whether the current character completes the code.
    always_comb begin
        hit = 1'b0;
        case (md)
            FC_FIRST:  hit = stb && (data == code_a);
            FC_SECOND: hit = stb && (data == code_b);
            FC_PAIR:   hit = stb && armed && (data == code_b);
            default:   hit = 1'b0;
        endcase
    end

    // Track a pending first byte in two-byte mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (md != FC_PAIR) begin
            armed <= 1'b0;
        end else if (stb) begin
            if (armed && (data == code_b)) begin
                armed <= 1'b0;
            end else begin
                armed <= (data == code_a);
            end
        end
    end
endmodule

// File: rtl/swfc_rxtrack.sv
// Receive-side status: one matcher for the resume code and one for the stop code.
// Keeps the local pause status and raises the stop interrupt pulse.
// Assumes: the codes are stable while characters arrive.
module swfc_rxtrack
    import swfc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic          xany,
    input  logic [DW-1:0] xon_a,
    input  logic [DW-1:0] xon_b,
    input  logic [DW-1:0] xoff_a,
    input  logic [DW-1:0] xoff_b,
    input  logic          stb,
    input  logic [DW-1:0] data,
    output logic          paused,
    output logic          irq
);
    localparam int NCODE  = 2;
    localparam int IX_ON  = 0;
    localparam int IX_OFF = 1;

    fc_mode_e                    md;
    logic [NCODE-1:0]            hit;
    logic [NCODE-1:0][DW-1:0]    ca;
    logic [NCODE-1:0][DW-1:0]    cb;

    assign md = fc_mode_e'(mode);
    assign ca = {xoff_a, xon_a};
    assign cb = {xoff_b, xon_b};

    for (genvar k = 0; k < NCODE; k++) begin : g_match
        swfc_rxmatch #(.DW(DW)) u_match (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode   (mode),
            .code_a (ca[k]),
            .code_b (cb[k]),
            .stb    (stb),
            .data   (data),
            .hit    (hit[k])
        );
    end

    // Update the pause status and the interrupt pulse; a stop code has precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paused <= 1'b0;
            irq    <= 1'b0;
        end else if (md == FC_OFF) begin
            paused <= 1'b0;
            irq    <= 1'b0;
        end else begin
            irq <= hit[IX_OFF];
            if (hit[IX_OFF]) begin
                paused <= 1'b1;
            end else if (hit[IX_ON]) begin
                paused <= 1'b0;
            end else if (stb && xany) begin
                paused <= 1'b0;
            end
        end
    end

    // R10: an interrupt pulse only follows a character strobe.
    a_r10_irq_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(stb));
    // R10: the interrupt pulse comes with the paused status.
    a_r10_irq_with_pause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> paused);
    // R6: mode off clears the status and the interrupt.
    a_r6_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (md == FC_OFF) |=> (!paused && !irq));
    // R9: the pause status is never left without a received character.
    a_r9_no_idle_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && !stb && md != FC_OFF) |=> paused);
endmodule

// File: rtl/swfc_txgen.sv
// Transmit-side code generator: compares the receive level with the thresholds.
// Offers stop/resume code bytes to the serializer with a request/acknowledge handshake.
// Assumes: ins ack is high for one cycle when the offered byte starts.
module swfc_txgen
    import swfc_pkg::*;
#(
    parameter int CW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] hi,
    input  logic [CW-1:0] lo,
    input  logic [DW-1:0] xon_a,
    input  logic [DW-1:0] xon_b,
    input  logic [DW-1:0] xoff_a,
    input  logic [DW-1:0] xoff_b,
    input  logic          ack,
    output logic          req,
    output logic [DW-1:0] code
);
    fc_mode_e  md;
    tg_state_e st;
    logic      remote_off;
    logic      send_off;
    logic      want_off;
    logic      want_on;

    assign md       = fc_mode_e'(mode);
    assign want_off = !remote_off && (level > hi);
    assign want_on  = remote_off && (level <= lo);
    assign req      = (st != TG_IDLE);

    // Sequence the insertion of one or two code bytes and track the far end's state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= TG_IDLE;
            remote_off <= 1'b0;
            send_off   <= 1'b0;
            code       <= '0;
        end else if (md == FC_OFF) begin
            st         <= TG_IDLE;
            remote_off <= 1'b0;
        end else begin
            case (st)
                TG_IDLE: begin
                    if (want_off) begin
                        st         <= TG_BYTE1;
                        remote_off <= 1'b1;
                        send_off   <= 1'b1;
                        code       <= (md == FC_SECOND) ? xoff_b : xoff_a;
                    end else if (want_on) begin
                        st         <= TG_BYTE1;
                        remote_off <= 1'b0;
                        send_off   <= 1'b0;
                        code       <= (md == FC_SECOND) ? xon_b : xon_a;
                    end
                end
                TG_BYTE1: begin
                    if (ack) begin
                        if (md == FC_PAIR) begin
                            st   <= TG_BYTE2;
                            code <= send_off ? xoff_b : xon_b;
                        end else begin
                            st <= TG_IDLE;
                        end
                    end
                end
                TG_BYTE2: begin
                    if (ack) begin
                        st <= TG_IDLE;
                    end
                end
                default: st <= TG_IDLE;
            endcase
        end
    end

    // R2: mode off withdraws any request.
    a_r2_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (md == FC_OFF) |=> !req);
    // R5: an unacknowledged byte is held.
    a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && md != FC_OFF) |=> (req && $stable(code)));
endmodule

// File: rtl/swfc_ctrl.sv
// Top of the software flow controller for one channel.
// Joins receive-side recognition and transmit-side code generation.
// Assumes: the serializer sends an offered code before FIFO data, between characters only.
module swfc_ctrl
    import swfc_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       tx_mode,
    input  logic [1:0]       rx_mode,
    input  logic             xon_any,
    input  logic [7:0]       xon_code1,
    input  logic [7:0]       xon_code2,
    input  logic [7:0]       xoff_code1,
    input  logic [7:0]       xoff_code2,
    input  logic [CNT_W-1:0] thr_hi,
    input  logic [CNT_W-1:0] thr_lo,
    input  logic             rx_stb,
    input  logic [7:0]       rx_char,
    input  logic [CNT_W-1:0] rx_level,
    input  logic             ins_ack,
    output logic             tx_pause,
    output logic             ins_req,
    output logic [7:0]       ins_code,
    output logic             xoff_irq
);
    localparam int DW = 8;

    logic paused;

    swfc_rxtrack #(.DW(DW)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (rx_mode),
        .xany   (xon_any),
        .xon_a  (xon_code1),
        .xon_b  (xon_code2),
        .xoff_a (xoff_code1),
        .xoff_b (xoff_code2),
        .stb    (rx_stb),
        .data   (rx_char),
        .paused (paused),
        .irq    (xoff_irq)
    );

    swfc_txgen #(.CW(CNT_W), .DW(DW)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (tx_mode),
        .level  (rx_level),
        .hi     (thr_hi),
        .lo     (thr_lo),
        .xon_a  (xon_code1),
        .xon_b  (xon_code2),
        .xoff_a (xoff_code1),
        .xoff_b (xoff_code2),
        .ack    (ins_ack),
        .req    (ins_req),
        .code   (ins_code)
    );

    // FIFO data waits while paused or while a code byte is pending.
    assign tx_pause = paused | ins_req;
endmodule

// File: tb/test_swfc_ctrl.sv
`timescale 1ns/1ps
module test_swfc_ctrl;
    localparam int CW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    tx_mode = 2'b00;
    logic [1:0]    rx_mode = 2'b00;
    logic          xon_any = 1'b0;
    logic [7:0]    xon_code1 = 8'h11;
    logic [7:0]    xon_code2 = 8'h13;
    logic [7:0]    xoff_code1 = 8'h19;
    logic [7:0]    xoff_code2 = 8'h93;
    logic [CW-1:0] thr_hi = 9'd8;
    logic [CW-1:0] thr_lo = 9'd2;
    logic          rx_stb = 1'b0;
    logic [7:0]    rx_char = 8'h00;
    logic [CW-1:0] rx_level = '0;
    logic          ins_ack = 1'b0;
    logic          tx_pause, ins_req, xoff_irq;
    logic [7:0]    ins_code;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    ack_en = 1'b1;
    int    ack_lat = 2;
    int    ack_wait = 0;

    always #4 clk = ~clk;

    swfc_ctrl #(.CNT_W(CW)) i_swfc_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .rx_mode(rx_mode),
        .xon_any(xon_any), .xon_code1(xon_code1), .xon_code2(xon_code2),
        .xoff_code1(xoff_code1), .xoff_code2(xoff_code2),
        .thr_hi(thr_hi), .thr_lo(thr_lo), .rx_stb(rx_stb), .rx_char(rx_char),
        .rx_level(rx_level), .ins_ack(ins_ack), .tx_pause(tx_pause),
        .ins_req(ins_req), .ins_code(ins_code), .xoff_irq(xoff_irq)
    );

    task automatic chk(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int   m_roff = 0, m_st = 0, m_kind = 0, m_prev = -1;
    int   m_code = 0;
    bit   m_paused = 0, m_irq = 0, m_on_h = 0, m_off_h = 0;

    function automatic bit m_match(input int mode, input int a, input int b,
                                   input int d, input int prev);
        if (mode == 1) return d == a;
        if (mode == 2) return d == b;
        if (mode == 3) return (prev == a) && (d == b);
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_roff = 0; m_st = 0; m_kind = 0; m_code = 0;
            m_paused = 0; m_irq = 0; m_prev = -1;
        end else begin
            // transmit side
            if (tx_mode == 2'b00) begin
                m_st = 0; m_roff = 0;
            end else if (m_st == 0) begin
                if (m_roff == 0 && rx_level > thr_hi) begin
                    m_roff = 1; m_kind = 1; m_st = 1;
                    m_code = (tx_mode == 2'b10) ? xoff_code2 : xoff_code1;
                end else if (m_roff == 1 && rx_level <= thr_lo) begin
                    m_roff = 0; m_kind = 0; m_st = 1;
                    m_code = (tx_mode == 2'b10) ? xon_code2 : xon_code1;
                end
            end else if (m_st == 1) begin
                if (ins_ack) begin
                    if (tx_mode == 2'b11) begin
                        m_st = 2;
                        m_code = m_kind ? xoff_code2 : xon_code2;
                    end else m_st = 0;
                end
            end else if (ins_ack) m_st = 0;
            // receive side
            if (rx_mode == 2'b00) begin
                m_paused = 0; m_irq = 0; m_prev = -1;
            end else begin
                m_on_h  = rx_stb && m_match(rx_mode, xon_code1, xon_code2, rx_char, m_prev);
                m_off_h = rx_stb && m_match(rx_mode, xoff_code1, xoff_code2, rx_char, m_prev);
                m_irq = m_off_h;
                if (m_off_h) m_paused = 1;
                else if (m_on_h) m_paused = 0;
                else if (rx_stb && xon_any) m_paused = 0;
                if (rx_mode != 2'b11) m_prev = -1;
                else if (rx_stb) m_prev = (m_on_h || m_off_h) ? -1 : int'(rx_char);
            end
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk({cur_req, " tx_pause"}, tx_pause, int'(m_paused || m_st != 0));
            chk({cur_req, " ins_req"}, ins_req, int'(m_st != 0));
            chk({cur_req, " xoff_irq"}, xoff_irq, int'(m_irq));
            if (m_st != 0) chk({cur_req, " ins_code"}, ins_code, m_code);
        end
    end

    // Serializer stand-in: acknowledges an offered byte after a latency.
    always @(negedge clk) begin
        if (ins_ack) ins_ack = 1'b0;
        else if (ack_en && ins_req) begin
            if (ack_wait >= ack_lat) begin
                ins_ack = 1'b1; ack_wait = 0;
            end else ack_wait++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d);
        @(negedge clk);
        rx_stb = 1'b1; rx_char = d;
        @(negedge clk);
        rx_stb = 1'b0;
    endtask

    task automatic wait_code(input string tag, input int code);
        bit seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ins_req && ins_code == code) seen = 1;
        end
        chk(tag, int'(seen), 1);
    endtask

    initial begin
        cyc(3);
        chk("R1 tx_pause", tx_pause, 0);
        chk("R1 ins_req", ins_req, 0);
        chk("R1 xoff_irq", xoff_irq, 0);
        rst_n = 1'b1;

        // R4: enable with a moderate level sends nothing
        cur_req = "R4"; tx_mode = 2'b01; rx_level = 9'd5; cyc(8);
        chk("R4 no start-up resume", ins_req, 0);
        // R3: equal is not above; above sends the stop code once
        cur_req = "R3"; rx_level = 9'd8; cyc(4);
        chk("R3 equal level", ins_req, 0);
        rx_level = 9'd9; cyc(1);
        chk("R3 request", ins_req, 1);
        chk("R3 stop code", ins_code, 8'h19);
        cyc(10); rx_level = 9'd20; cyc(6);
        chk("R3 no repeat", ins_req, 0);
        // R4: hysteresis
        cur_req = "R4"; rx_level = 9'd5; cyc(6);
        chk("R4 above low", ins_req, 0);
        rx_level = 9'd2; cyc(1);
        chk("R4 resume request", ins_req, 1);
        chk("R4 resume code", ins_code, 8'h11);
        cyc(10);
        // R5: two-byte sequence, held without ack
        cur_req = "R5"; tx_mode = 2'b11; ack_en = 1'b0; ack_wait = 0; rx_level = 9'd30;
        cyc(7);
        chk("R5 held req", ins_req, 1);
        chk("R5 held code", ins_code, 8'h19);
        ack_en = 1'b1;
        wait_code("R5 second stop byte", 8'h93);
        rx_level = 9'd0; cyc(1);
        chk("R5 first resume byte", ins_code, 8'h11);
        wait_code("R5 second resume byte", 8'h13);
        // R2: second-byte mode, then off clears far-end status
        cur_req = "R2"; tx_mode = 2'b10; rx_level = 9'd30;
        wait_code("R2 second-only stop", 8'h93);
        tx_mode = 2'b00; cyc(4); rx_level = 9'd0; cyc(4);
        chk("R2 off no resume", ins_req, 0);
        rx_level = 9'd30; cyc(4);
        chk("R2 off no stop", ins_req, 0);
        tx_mode = 2'b10;
        wait_code("R2 stop after re-enable", 8'h93);
        rx_level = 9'd0;
        wait_code("R2 resume second byte", 8'h13);
        cyc(6); tx_mode = 2'b00; cyc(2);

        // R7 / R10: single first-byte codes
        cur_req = "R7"; rx_mode = 2'b01;
        send(8'h19);
        chk("R7 paused", tx_pause, 1);
        chk("R10 pulse", xoff_irq, 1);
        cyc(1);
        chk("R10 one cycle", xoff_irq, 0);
        send(8'h11);
        chk("R7 resumed", tx_pause, 0);
        // R6: second-byte matching
        cur_req = "R6"; rx_mode = 2'b10;
        send(8'h19); chk("R6 first byte ignored", tx_pause, 0);
        send(8'h93); chk("R6 second byte stops", tx_pause, 1);
        send(8'h11); chk("R6 resume first ignored", tx_pause, 1);
        send(8'h13); chk("R6 resume second", tx_pause, 0);
        // R8: two-byte matching
        cur_req = "R8"; rx_mode = 2'b11;
        send(8'h19); send(8'h19); send(8'h93);
        chk("R8 repeated first stop", tx_pause, 1);
        send(8'h11); send(8'h55); send(8'h13);
        chk("R8 foreign breaks match", tx_pause, 1);
        send(8'h11); send(8'h11); send(8'h13);
        chk("R8 repeated first resume", tx_pause, 0);
        send(8'h19); cyc(5); send(8'h93);
        chk("R8 idle gap keeps match", tx_pause, 1);
        send(8'h11); send(8'h13);
        chk("R8 pair resume", tx_pause, 0);
        // R9: any character resumes
        cur_req = "R9"; rx_mode = 2'b01; xon_any = 1'b1;
        send(8'h19); send(8'h41);
        chk("R9 any resumes", tx_pause, 0);
        send(8'h19); send(8'h19);
        chk("R9 stop wins", tx_pause, 1);
        chk("R10 pulse when already paused", xoff_irq, 1);
        send(8'h93);
        chk("R9 unmatched char resumes", tx_pause, 0);
        xon_any = 1'b0;
        send(8'h19); send(8'h41);
        chk("R9 option off", tx_pause, 1);
        // R6: receive side off
        cur_req = "R6"; rx_mode = 2'b00; cyc(1);
        chk("R6 off clears", tx_pause, 0);
        send(8'h19);
        chk("R6 off ignores", tx_pause, 0);
        chk("R6 off no irq", xoff_irq, 0);
        // R11: pending insertion holds FIFO data
        cur_req = "R11"; tx_mode = 2'b01; rx_level = 9'd30; cyc(1);
        chk("R11 pause with request", tx_pause, 1);
        chk("R11 request", ins_req, 1);
        cyc(10);
        chk("R11 released", tx_pause, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule